// File: doc/BRIEF.md
# Smart-panel parallel bus bridge

This block turns word writes on a simple 32-bit register bus into cycles on a 16-bit parallel bus of the kind used by display panels that keep their own frame memory. The panel side has two active-low chip selects, a data/command select line, active-low write and read strobes, a 16-bit output data bus with an output-enable, and a 16-bit input data bus. Software sends commands and parameters one register write at a time, streams pixel words through a data register (each 32-bit write becomes two 16-bit panel writes, low half first), and reads panel registers by writing a trigger register and then reading a receive buffer.

A pixel counter tracks how many data or read accesses remain in a transfer. A frame transfer is armed by a control write; the block then reports busy until the counter runs down to zero, at which point busy drops and a one-clock frame-done pulse is emitted. While a panel cycle is in progress the bridge holds its wait output high and takes no register write, so the bus master sees wait states. Timing and pixel-format words are kept only as plain storage.

Top module: `rfb_bridge`

## Requirements
- R1: Registers are selected by the word index on `bus_addr`: 0 control, 1 sysconfig, 2 sysstatus, 3 pixel count, 4 line number, 5 command, 6 parameter, 7 data, 8 read trigger, 9 status trigger, 10 config A, 11 config B, 12 upward NSTORE plain storage words; any other index reads as 0 and writes to it change nothing.
- R2: After reset control reads 2, config A and B read 0x00310000, sysstatus reads 1, and pixel count, line, sysconfig and the storage words read 0; all chip selects and strobes are high.
- R3: Control bits are [0] enable, [1] bypass, [2] chip-select-0 enable, [3] chip-select-1 enable. A command write makes one panel write with the select line low carrying the low 16 bits, driving every enabled chip select low together; with no chip enabled no panel cycle occurs.
- R4: A parameter write makes one panel write like R3 but with the select line high.
- R5: A data write makes two back-to-back panel writes with the select line high: low 16 bits first, then high 16 bits; the data bus is stable through each cycle.
- R6: Each panel cycle is 1 clock of setup (chip select asserted, strobe high), 2 clocks of strobe low, 1 clock of hold; `bus_wait` is high from the clock after the write is taken until the last cycle ends, and a write presented while `bus_wait` is high is not taken.
- R7: A read-trigger write makes a panel read with the select line high, a status-trigger write one with it low; only chip 0 is selected if enabled, otherwise chip 1, otherwise no cycle. `pnl_din` is captured in the second strobe clock into a 16-bit receive buffer that both trigger indices return on read.
- R8: Every data, read-trigger or status-trigger write decrements the pixel count modulo 2^PIX_W, whether or not a panel cycle runs; the count is writable and readable.
- R9: A control write with bit 4 set arms a transfer (busy = 1) only if the written enable bit is 1, the written bypass bit is 0, busy is 0 and `host_frame_mode` is 1. Sysstatus reads bit 0 = 1 and bit 8 = busy.
- R10: When a decrement brings the pixel count to zero while busy, busy clears and `frame_done` is high for exactly one clock after that write.
- R11: A sysconfig write with bit 1 set returns all registers except the receive buffer to their R2 values, clears busy, and stores the written idle field masked with 0x19.
- R12: Writes keep only the low 4 control bits, sysconfig bits under 0x19, 11 line bits, and config A/B bits under 0x003F1FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write request |
| bus_addr | input | 5 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| bus_wait | output | 1 | Panel cycle in progress; writes not taken |
| host_frame_mode | input | 1 | Display controller selects this bridge for frame output |
| frame_done | output | 1 | One-clock pulse when an armed transfer ends |
| pnl_cs_n | output | 2 | Panel chip selects, active low |
| pnl_dc | output | 1 | Data/command select, low for command or status |
| pnl_wr_n | output | 1 | Panel write strobe, active low |
| pnl_rd_n | output | 1 | Panel read strobe, active low |
| pnl_dout | output | 16 | Panel write data |
| pnl_oe | output | 1 | Panel data output enable |
| pnl_din | input | 16 | Panel read data |

## Verification
The bench builds the bridge with an 8-bit pixel counter and four storage words. The narrow counter lets a decrement from zero wrap to 255 within a handful of writes, and keeps multi-word frame countdowns short, while the four storage words place index 16 just outside the storage range so the read-as-zero rule of unmapped indices is reached.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  localparam int REG_AW = 5;
  localparam int PNL_W  = 16;

  typedef enum logic [REG_AW-1:0] {
    IX_CTRL    = 5'd0,
    IX_SYSCFG  = 5'd1,
    IX_SYSSTAT = 5'd2,
    IX_PIXCNT  = 5'd3,
    IX_LINE    = 5'd4,
    IX_CMD     = 5'd5,
    IX_PARAM   = 5'd6,
    IX_DATA    = 5'd7,
    IX_READ    = 5'd8,
    IX_STAT    = 5'd9,
    IX_CFGA    = 5'd10,
    IX_CFGB    = 5'd11,
    IX_STORE0  = 5'd12
  } reg_ix_e;

  localparam logic [31:0] CFG_RESET  = 32'h0031_0000;
  localparam logic [31:0] CFG_MASK   = 32'h003F_1FFF;
  localparam logic [3:0]  CTRL_RESET = 4'h2;
  localparam logic [4:0]  IDLE_MASK  = 5'h19;

  // sysstatus word: bit 0 always set, bit 8 mirrors busy
  function automatic logic [31:0] sysstat_word(input logic busy);
    return {23'd0, busy, 7'd0, 1'b1};
  endfunction

  // read source: chip 0 wins when both are enabled
  function automatic logic [1:0] read_chip(input logic [1:0] en);
    if (en[0]) return 2'b01;
    if (en[1]) return 2'b10;
    return 2'b00;
  endfunction

  // transfer arm condition, judged on the control value being written
  function automatic logic start_ok(input logic [31:0] wv, input logic busy,
                                    input logic mode);
    return wv[4] & wv[0] & ~wv[1] & ~busy & mode;
  endfunction
endpackage

// File: rtl/rfb_panel_seq.sv
module rfb_panel_seq
  import rfb_pkg::*;
#(
  parameter int SETUP  = 1,
  parameter int STROBE = 2,
  parameter int HOLD   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               req_rd,
  input  logic               req_dc,
  input  logic               req_two,
  input  logic [1:0]         req_cs,
  input  logic [2*PNL_W-1:0] req_word,
  output logic               active,
  output logic [PNL_W-1:0]   rx_word,
  output logic [1:0]         pnl_cs_n,
  output logic               pnl_dc,
  output logic               pnl_wr_n,
  output logic               pnl_rd_n,
  output logic [PNL_W-1:0]   pnl_dout,
  output logic               pnl_oe,
  input  logic [PNL_W-1:0]   pnl_din
);
  localparam int LAST_I = SETUP + STROBE + HOLD - 1;
  localparam int PW     = $clog2(LAST_I + 1);
  localparam logic [PW-1:0] P_LAST = PW'(LAST_I);
  localparam logic [PW-1:0] P_SON  = PW'(SETUP);
  localparam logic [PW-1:0] P_CAP  = PW'(SETUP + STROBE - 1);

  logic               act_q, beat_q, two_q, rd_q, dc_q;
  logic [1:0]         cs_q;
  logic [2*PNL_W-1:0] word_q;
  logic [PW-1:0]      ph_q;
  logic [PNL_W-1:0]   rx_q;

  logic stb_win, cap_evt, end_evt;
  assign stb_win = act_q && (ph_q >= P_SON) && (ph_q <= P_CAP);
  assign cap_evt = act_q && rd_q && (ph_q == P_CAP);
  assign end_evt = act_q && (ph_q == P_LAST) && !(two_q && !beat_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; beat_q <= 1'b0; two_q <= 1'b0; rd_q <= 1'b0; dc_q <= 1'b0;
      cs_q <= 2'b00; word_q <= '0; ph_q <= '0; rx_q <= '0;
    end else if (req && !act_q) begin
      act_q <= 1'b1; ph_q <= '0; beat_q <= 1'b0;
      two_q <= req_two; rd_q <= req_rd; dc_q <= req_dc;
      cs_q <= req_cs; word_q <= req_word;
    end else if (act_q) begin
      if (cap_evt) rx_q <= pnl_din;
      if (ph_q == P_LAST) begin
        if (end_evt) act_q <= 1'b0;
        else begin beat_q <= 1'b1; ph_q <= '0; end
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign active   = act_q;
  assign rx_word  = rx_q;
  assign pnl_cs_n = act_q ? ~cs_q : 2'b11;
  assign pnl_dc   = act_q & dc_q;
  assign pnl_wr_n = ~(stb_win & ~rd_q);
  assign pnl_rd_n = ~(stb_win & rd_q);
  assign pnl_oe   = act_q & ~rd_q;
  assign pnl_dout = (act_q && !rd_q) ? (beat_q ? word_q[2*PNL_W-1:PNL_W] : word_q[PNL_W-1:0])
                                     : '0;

  // R6: a strobe is never low without a chip select low
  p_strobe_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pnl_wr_n || !pnl_rd_n) |-> (pnl_cs_n != 2'b11));
  // R6: write and read strobes never overlap
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!pnl_wr_n && !pnl_rd_n));
  // R7: a read cycle selects exactly one chip
  p_read_one_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pnl_rd_n) |-> ($countones(~pnl_cs_n) == 1));
  // R5: write data holds still within a beat
  p_dout_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && ph_q != '0 && $past(act_q)) |-> $stable(pnl_dout));
endmodule

// File: rtl/rfb_xfer_ctl.sv
module rfb_xfer_ctl #(
  parameter int PIX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             pix_wr,
  input  logic [PIX_W-1:0] pix_wdata,
  input  logic             dec_evt,
  input  logic             start_evt,
  output logic [PIX_W-1:0] pix,
  output logic             busy,
  output logic             done
);
  logic [PIX_W-1:0] pix_q;
  logic             busy_q, done_q;
  logic             last_evt;

  // the access that takes the count from one to zero ends an armed transfer
  assign last_evt = dec_evt && busy_q && (pix_q == PIX_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (soft_rst) begin
        pix_q <= '0; busy_q <= 1'b0;
      end else begin
        if (pix_wr)    pix_q  <= pix_wdata;
        if (start_evt) busy_q <= 1'b1;
        if (dec_evt)   pix_q  <= pix_q - 1'b1;
        if (last_evt) begin busy_q <= 1'b0; done_q <= 1'b1; end
      end
    end
  end

  assign pix  = pix_q;
  assign busy = busy_q;
  assign done = done_q;

  // R9: an accepted arm raises busy on the next clock
  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !soft_rst) |=> busy_q);
  // R10: frame done is a single-clock pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R10: busy is low whenever done is shown
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  // R10: busy only falls by countdown or soft reset
  p_busy_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && !$past(soft_rst)) |-> done_q);
endmodule

// File: rtl/rfb_bridge.sv
module rfb_bridge
  import rfb_pkg::*;
#(
  parameter int PIX_W  = 16,
  parameter int LINE_W = 11,
  parameter int NSTORE = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_wait,
  input  logic              host_frame_mode,
  output logic              frame_done,
  output logic [1:0]        pnl_cs_n,
  output logic              pnl_dc,
  output logic              pnl_wr_n,
  output logic              pnl_rd_n,
  output logic [PNL_W-1:0]  pnl_dout,
  output logic              pnl_oe,
  input  logic [PNL_W-1:0]  pnl_din
);
  localparam int NREG = 1 << REG_AW;

  logic [3:0]        ctrl_q;
  logic [4:0]        idle_q;
  logic [LINE_W-1:0] line_q;
  logic [31:0]       cfg_q [2];
  logic [31:0]       store_q [NSTORE];

  logic              seq_active;
  logic [PNL_W-1:0]  rx_word;
  logic [PIX_W-1:0]  pix;
  logic              busy;

  // one-hot write select for the taken write
  logic [NREG-1:0] wsel;
  logic            wr_ok, soft_rst, launch_wr, launch_rd, dec_evt, start_evt;
  logic [1:0]      cs_en, rd_cs;

  assign wr_ok     = bus_wr & ~seq_active;
  assign wsel      = wr_ok ? (NREG'(1) << bus_addr) : '0;
  assign soft_rst  = wsel[IX_SYSCFG] & bus_wdata[1];
  assign cs_en     = ctrl_q[3:2];
  assign rd_cs     = read_chip(cs_en);
  assign launch_wr = (wsel[IX_CMD] | wsel[IX_PARAM] | wsel[IX_DATA]) & (|cs_en);
  assign launch_rd = (wsel[IX_READ] | wsel[IX_STAT]) & (|rd_cs);
  assign dec_evt   = wsel[IX_DATA] | wsel[IX_READ] | wsel[IX_STAT];
  assign start_evt = wsel[IX_CTRL] & start_ok(bus_wdata, busy, host_frame_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET; idle_q <= '0; line_q <= '0;
      cfg_q[0] <= CFG_RESET; cfg_q[1] <= CFG_RESET;
    end else if (soft_rst) begin
      ctrl_q <= CTRL_RESET; line_q <= '0;
      cfg_q[0] <= CFG_RESET; cfg_q[1] <= CFG_RESET;
      idle_q <= bus_wdata[4:0] & IDLE_MASK;
    end else begin
      if (wsel[IX_CTRL])   ctrl_q   <= bus_wdata[3:0];
      if (wsel[IX_SYSCFG]) idle_q   <= bus_wdata[4:0] & IDLE_MASK;
      if (wsel[IX_LINE])   line_q   <= bus_wdata[LINE_W-1:0];
      if (wsel[IX_CFGA])   cfg_q[0] <= bus_wdata & CFG_MASK;
      if (wsel[IX_CFGB])   cfg_q[1] <= bus_wdata & CFG_MASK;
    end
  end

  for (genvar g = 0; g < NSTORE; g++) begin : g_store
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         store_q[g] <= '0;
      else if (soft_rst)                  store_q[g] <= '0;
      else if (wsel[int'(IX_STORE0) + g]) store_q[g] <= bus_wdata;
    end
  end

  rfb_panel_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (launch_wr | launch_rd),
    .req_rd   (launch_rd),
    .req_dc   (~(wsel[IX_CMD] | wsel[IX_STAT])),
    .req_two  (wsel[IX_DATA]),
    .req_cs   (launch_rd ? rd_cs : cs_en),
    .req_word (bus_wdata),
    .active   (seq_active),
    .rx_word  (rx_word),
    .pnl_cs_n (pnl_cs_n),
    .pnl_dc   (pnl_dc),
    .pnl_wr_n (pnl_wr_n),
    .pnl_rd_n (pnl_rd_n),
    .pnl_dout (pnl_dout),
    .pnl_oe   (pnl_oe),
    .pnl_din  (pnl_din)
  );

  rfb_xfer_ctl #(.PIX_W(PIX_W)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .pix_wr    (wsel[IX_PIXCNT]),
    .pix_wdata (bus_wdata[PIX_W-1:0]),
    .dec_evt   (dec_evt),
    .start_evt (start_evt),
    .pix       (pix),
    .busy      (busy),
    .done      (frame_done)
  );

  assign bus_wait = seq_active;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      IX_CTRL:         bus_rdata = {28'd0, ctrl_q};
      IX_SYSCFG:       bus_rdata = {27'd0, idle_q};
      IX_SYSSTAT:      bus_rdata = sysstat_word(busy);
      IX_PIXCNT:       bus_rdata = {{(32-PIX_W){1'b0}}, pix};
      IX_LINE:         bus_rdata = {{(32-LINE_W){1'b0}}, line_q};
      IX_READ, IX_STAT: bus_rdata = {16'd0, rx_word};
      IX_CFGA:         bus_rdata = cfg_q[0];
      IX_CFGB:         bus_rdata = cfg_q[1];
      default: begin
        for (int i = 0; i < NSTORE; i++)
          if (int'(bus_addr) == int'(IX_STORE0) + i) bus_rdata = store_q[i];
      end
    endcase
  end

  // R6: a strobe only happens while the bus master is held off
  p_strobe_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pnl_wr_n || !pnl_rd_n) |-> bus_wait);
  // R10: frame done only follows a counting access
  p_done_after_dec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(dec_evt));
endmodule

// File: tb/rfb_bridge_test.sv
module rfb_bridge_test;
  localparam int PIX_W  = 8;
  localparam int NSTORE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_wait;
  logic        host_frame_mode = 1'b0;
  logic        frame_done;
  logic [1:0]  pnl_cs_n;
  logic        pnl_dc, pnl_wr_n, pnl_rd_n, pnl_oe;
  logic [15:0] pnl_dout;
  logic [15:0] pnl_din = '0;

  always #4 clk = ~clk;

  rfb_bridge #(.PIX_W(PIX_W), .NSTORE(NSTORE)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
    .host_frame_mode(host_frame_mode), .frame_done(frame_done),
    .pnl_cs_n(pnl_cs_n), .pnl_dc(pnl_dc), .pnl_wr_n(pnl_wr_n), .pnl_rd_n(pnl_rd_n),
    .pnl_dout(pnl_dout), .pnl_oe(pnl_oe), .pnl_din(pnl_din)
  );

  int total = 0;
  int bad = 0;
  string cur_tag = "R2";

  // ---------------- reference model ----------------
  logic [3:0]       m_ctrl;
  logic [4:0]       m_idle;
  logic [10:0]      m_line;
  logic [31:0]      m_cfg [2];
  logic [31:0]      m_store [NSTORE];
  logic [PIX_W-1:0] m_pix;
  logic             m_busy, m_done, m_act;
  logic [15:0]      m_rx;
  int               m_ph;
  logic [19:0]      m_cur;      // {rd, dc, cs[1:0], data}
  logic [19:0]      beats [$];

  task automatic m_reset_regs();
    m_ctrl = 4'h2; m_line = '0; m_cfg[0] = 32'h0031_0000; m_cfg[1] = 32'h0031_0000;
    for (int i = 0; i < NSTORE; i++) m_store[i] = '0;
    m_pix = '0; m_busy = 1'b0;
  endtask

  task automatic m_count();
    m_pix = m_pix - 1'b1;
    if (m_pix == '0 && m_busy) begin m_busy = 1'b0; m_done = 1'b1; end
  endtask

  task automatic m_apply(input int ix, input logic [31:0] v);
    logic [1:0] sel;
    case (ix)
      0: begin
        if (v[4] && v[0] && !v[1] && !m_busy && host_frame_mode) m_busy = 1'b1;
        m_ctrl = v[3:0];
      end
      1: begin if (v[1]) m_reset_regs(); m_idle = v[4:0] & 5'h19; end
      3: m_pix = v[PIX_W-1:0];
      4: m_line = v[10:0];
      5: if (m_ctrl[3:2] != 0) beats.push_back({1'b0, 1'b0, m_ctrl[3:2], v[15:0]});
      6: if (m_ctrl[3:2] != 0) beats.push_back({1'b0, 1'b1, m_ctrl[3:2], v[15:0]});
      7: begin
        if (m_ctrl[3:2] != 0) begin
          beats.push_back({1'b0, 1'b1, m_ctrl[3:2], v[15:0]});
          beats.push_back({1'b0, 1'b1, m_ctrl[3:2], v[31:16]});
        end
        m_count();
      end
      8, 9: begin
        sel = m_ctrl[2] ? 2'b01 : (m_ctrl[3] ? 2'b10 : 2'b00);
        if (sel != 0) begin
          beats.push_back({1'b1, (ix == 8), sel, 16'h0000});
          m_rx = pnl_din;
        end
        m_count();
      end
      10: m_cfg[0] = v & 32'h003F_1FFF;
      11: m_cfg[1] = v & 32'h003F_1FFF;
      default: if (ix >= 12 && ix < 12 + NSTORE) m_store[ix-12] = v;
    endcase
  endtask

  function automatic logic [31:0] m_read(input int ix);
    case (ix)
      0: return {28'd0, m_ctrl};
      1: return {27'd0, m_idle};
      2: return {23'd0, m_busy, 7'd0, 1'b1};
      3: return {{(32-PIX_W){1'b0}}, m_pix};
      4: return {21'd0, m_line};
      8, 9: return {16'd0, m_rx};
      10: return m_cfg[0];
      11: return m_cfg[1];
      default: return (ix >= 12 && ix < 12 + NSTORE) ? m_store[ix-12] : 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reset_regs(); m_idle = '0; m_rx = '0; m_done = 1'b0; m_act = 1'b0; m_ph = 0;
      m_cur = '0; beats.delete();
    end else begin
      logic acc;
      acc = bus_wr && !m_act;
      m_done = 1'b0;
      if (m_act) begin
        m_ph++;
        if (m_ph == 4) begin
          if (beats.size() > 0) begin m_cur = beats.pop_front(); m_ph = 0; end
          else m_act = 1'b0;
        end
      end
      if (acc) begin
        m_apply(int'(bus_addr), bus_wdata);
        if (beats.size() > 0) begin m_cur = beats.pop_front(); m_act = 1'b1; m_ph = 0; end
      end
    end
  end

  // per-clock comparison of every output pin against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [23:0] exp_v, act_v;
      logic stb;
      stb = m_act && (m_ph == 1 || m_ph == 2);
      exp_v = {m_act ? ~m_cur[17:16] : 2'b11, m_act & m_cur[18],
               ~(stb & ~m_cur[19]), ~(stb & m_cur[19]),
               (m_act && !m_cur[19]) ? m_cur[15:0] : 16'h0000,
               m_act & ~m_cur[19], m_act, m_done};
      act_v = {pnl_cs_n, pnl_dc, pnl_wr_n, pnl_rd_n, pnl_dout, pnl_oe, bus_wait, frame_done};
      total++;
      if (act_v !== exp_v) begin
        bad++;
        $display("FAIL %s (R6 pins) t=%0t actual=%h expected=%h", cur_tag, $time, act_v, exp_v);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int ix, input logic [31:0] v);
    @(negedge clk);
    while (bus_wait) @(negedge clk);
    bus_addr = 5'(ix); bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle_wait();
    @(negedge clk);
    while (bus_wait) @(negedge clk);
  endtask

  task automatic rd_chk(input int ix, input string tag);
    logic [31:0] e;
    idle_wait();
    bus_addr = 5'(ix);
    #1;
    e = m_read(ix);
    total++;
    if (bus_rdata !== e) begin
      bad++;
      $display("FAIL %s reg %0d actual=%h expected=%h", tag, ix, bus_rdata, e);
    end
  endtask

  task automatic rd_exp(input int ix, input logic [31:0] e, input string tag);
    idle_wait();
    bus_addr = 5'(ix);
    #1;
    total++;
    if (bus_rdata !== e) begin
      bad++;
      $display("FAIL %s reg %0d actual=%h expected=%h", tag, ix, bus_rdata, e);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset values, fixed constants as well as model
    rd_exp(0, 32'h2, "R2");
    rd_exp(10, 32'h0031_0000, "R2");
    rd_exp(11, 32'h0031_0000, "R2");
    rd_exp(2, 32'h1, "R2");
    rd_exp(3, 32'h0, "R2");

    // R12 masks, R1 map
    cur_tag = "R12";
    wr(0, 32'hFFFF_FFE0); rd_exp(0, 32'h0, "R12");
    wr(10, 32'hFFFF_FFFF); rd_exp(10, 32'h003F_1FFF, "R12");
    wr(4, 32'hFFFF_FFFF);  rd_exp(4, 32'h7FF, "R12");
    wr(1, 32'hFFFF_FFFD);  rd_exp(1, 32'h19, "R12");
    cur_tag = "R1";
    wr(11, 32'h1234_5678); rd_chk(11, "R1");
    for (int i = 0; i < NSTORE; i++) wr(12 + i, 32'hA000_0000 + i);
    for (int i = 0; i < NSTORE; i++) rd_chk(12 + i, "R1");
    wr(16, 32'hDEAD_BEEF); rd_exp(16, 32'h0, "R1");

    // R3 command on each chip select, both, and none
    cur_tag = "R3";
    wr(0, 32'h4); wr(5, 32'hABCD_1234);
    wr(0, 32'h8); wr(5, 32'h0000_5A5A);
    wr(0, 32'hC); wr(5, 32'hFFFF_00FF);
    wr(0, 32'h0); wr(5, 32'h0000_7777);
    idle_wait();
    // R4 parameter
    cur_tag = "R4";
    wr(0, 32'hC); wr(6, 32'h5555_AAAA);
    wr(0, 32'h4); wr(6, 32'h0000_0F0F);
    // R5 data, R8 wrap from zero
    cur_tag = "R5";
    wr(3, 32'h0);
    wr(0, 32'hC); wr(7, 32'h89AB_4567);
    rd_exp(3, 32'hFF, "R8");
    wr(0, 32'h8); wr(7, 32'h0102_0304);
    rd_chk(3, "R8");

    // R6: write presented while wait is high is not taken
    cur_tag = "R6";
    wr(4, 32'h0);
    wr(0, 32'h4); wr(5, 32'h0000_1111);
    bus_addr = 5'd4; bus_wdata = 32'h123; bus_wr = 1'b1;   // wait is high here
    @(negedge clk); bus_wr = 1'b0;
    rd_exp(4, 32'h0, "R6");

    // R7 reads: chip 0 priority, chip 1 fallback, none
    cur_tag = "R7";
    wr(0, 32'hC); pnl_din = 16'h1357; wr(8, 32'h0);
    rd_exp(8, 32'h1357, "R7"); rd_exp(9, 32'h1357, "R7");
    wr(0, 32'h8); pnl_din = 16'h2468; wr(9, 32'h0);
    rd_exp(9, 32'h2468, "R7");
    wr(0, 32'h0); pnl_din = 16'hFFFF; wr(8, 32'h0);
    rd_exp(8, 32'h2468, "R7");
    cur_tag = "R8";
    wr(3, 32'h20); wr(9, 32'h0); wr(7, 32'h0);
    rd_exp(3, 32'h1E, "R8");

    // R9 start conditions
    cur_tag = "R9";
    wr(3, 32'h3);
    host_frame_mode = 1'b0; wr(0, 32'h15); rd_exp(2, 32'h1, "R9");
    host_frame_mode = 1'b1;
    wr(0, 32'h17); rd_exp(2, 32'h1, "R9");
    wr(0, 32'h14); rd_exp(2, 32'h1, "R9");
    wr(0, 32'h15); rd_exp(2, 32'h101, "R9");
    // R10 countdown to done
    cur_tag = "R10";
    wr(7, 32'h1111_2222); rd_exp(2, 32'h101, "R10");
    wr(7, 32'h3333_4444); rd_exp(2, 32'h101, "R10");
    wr(7, 32'h5555_6666); rd_exp(2, 32'h1, "R10");
    rd_exp(3, 32'h0, "R10");
    wr(7, 32'h0); rd_exp(2, 32'h1, "R10");

    // R11 soft reset during a transfer
    cur_tag = "R11";
    wr(3, 32'h5); wr(0, 32'h15); rd_exp(2, 32'h101, "R11");
    wr(4, 32'h55); wr(10, 32'h1);
    wr(1, 32'h0000_001B);
    rd_exp(1, 32'h19, "R11"); rd_exp(0, 32'h2, "R11"); rd_exp(2, 32'h1, "R11");
    rd_exp(3, 32'h0, "R11"); rd_exp(4, 32'h0, "R11"); rd_exp(10, 32'h0031_0000, "R11");
    rd_exp(12, 32'h0, "R11"); rd_exp(8, 32'h2468, "R11");

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule